// File: doc/BRIEF.md
# Renaming Register File

This block is the architectural register file of an out-of-order core, and it also does register renaming. Each register stores a 32-bit value, a ready flag and a reorder-buffer tag. While the ready flag is low, the value is still being computed by an in-flight instruction, and the tag names the reorder-buffer slot that will deliver it. A register can be in one of two states:

- **Ready**: the stored value is current.
- **Pending**: the value is still being computed.

Operand fetch reads this file first. A consumer goes to the reorder buffer only when the ready flag comes back low, and then it uses the returned tag.

The rename port accepts work with a valid/ready handshake:

- **Decode** offers a destination register and the freshly allocated tag on the rename port. The handshake completes when `ren_valid` and `ren_ready` are both high.
- **Back-pressure:** `ren_ready` falls only while `flush` is high. A rename offered in that cycle is not taken, and decode must hold it or drop it.

Commits arrive on a separate port that is always accepted:

- **Value:** a commit always stores its value.
- **Ready flag:** the commit makes the register ready again only when the committing tag is the register's current tag.
- **Stale writers:** an older writer that retires after a younger rename therefore cannot mark the register ready. Only the youngest writer's completion does that.

Flush makes every register ready and discards all pending mappings.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register is ready, holds value 0 and holds tag 0.
- R2: Each of the two read ports independently returns the value, ready flag and tag of the register it addresses, combinationally.
- R3: An accepted rename (ren_valid and ren_ready high at a clock edge) makes the named register pending, with the offered tag, from the next cycle. The register's value does not change.
- R4: While flush is high, ren_ready is low and an offered rename has no effect on any tag or ready flag.
- R5: A commit to a pending register whose tag equals the commit tag stores the commit value and makes the register ready.
- R6: A commit to a pending register whose tag differs from the commit tag stores the commit value, and the register stays pending with its existing tag.
- R7: A commit to a ready register stores the value and the register stays ready.
- R8: When a rename and a commit hit the same register in one cycle, the register ends pending with the rename tag and holds the commit value.
- R9: Flush makes every register ready and leaves the values and tags unchanged.
- R10: A read of the register being committed in the same cycle returns three things:
  - the commit value;
  - the ready flag the register will have after the commit (ready if it was ready, or if its tag equals the commit tag);
  - its stored tag.
- R11: Register index 0 is renamed and committed like any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all pending mappings |
| ren_valid | input | 1 | Rename request offered |
| ren_ready | output | 1 | Rename can be accepted (low during flush) |
| ren_reg | input | 4 | Destination register to rename |
| ren_tag | input | 3 | Reorder-buffer tag allocated to it |
| cmt_valid | input | 1 | Commit present this cycle |
| cmt_reg | input | 4 | Register being committed |
| cmt_tag | input | 3 | Tag of the committing entry |
| cmt_data | input | 32 | Committed value |
| rd_addr | input | 2x4 | Read addresses, one per port |
| rd_data | output | 2x32 | Read values (commit bypassed) |
| rd_valid | output | 2 | Read ready flags |
| rd_tag | output | 2x3 | Read tags |

## Verification
The properties assume that the rename, commit and flush inputs are never unknown while out of reset. They also assume that a commit names a register and tag the way the reorder buffer would, but they do not require tags to be unique. The stimulus drives every input at the falling edge and returns the handshake and commit pins to zero between operations. It issues renames only with distinct live tags per register, mirroring an eight-entry buffer. Two colliding cases are driven deliberately:
- a rename and a commit to the same register in one cycle;
- a rename offered together with a flush.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  // Next-state choice for one register's ready flag
  typedef enum logic [1:0] {
    VS_KEEP  = 2'd0,
    VS_SET   = 2'd1,
    VS_CLEAR = 2'd2
  } vsel_e;

endpackage

// File: rtl/rrf_update_ctl.sv
module rrf_update_ctl
  import rrf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                     flush,
  input  logic                     ren_fire,
  input  logic [RW-1:0]            ren_reg,
  input  logic                     cmt_valid,
  input  logic [RW-1:0]            cmt_reg,
  input  logic [TW-1:0]            cmt_tag,
  input  logic [NREG-1:0]          cur_valid,
  input  logic [NREG-1:0][TW-1:0]  cur_tag,
  output vsel_e                    vsel    [NREG],
  output logic [NREG-1:0]          tag_we,
  output logic [NREG-1:0]          data_we
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic hit_ren, hit_cmt, youngest;

    assign hit_ren  = ren_fire  && (ren_reg == RW'(i));
    assign hit_cmt  = cmt_valid && (cmt_reg == RW'(i));
    assign youngest = !cur_valid[i] && (cur_tag[i] == cmt_tag);

    // flush > rename > matching commit
    always_comb begin
      if (flush)                    vsel[i] = VS_SET;
      else if (hit_ren)             vsel[i] = VS_CLEAR;
      else if (hit_cmt && youngest) vsel[i] = VS_SET;
      else                          vsel[i] = VS_KEEP;
    end

    assign tag_we[i]  = hit_ren;
    assign data_we[i] = hit_cmt;
  end

endmodule

// File: rtl/rrf_state.sv
module rrf_state
  import rrf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  vsel_e                    vsel    [NREG],
  input  logic [NREG-1:0]          tag_we,
  input  logic [TW-1:0]            new_tag,
  input  logic [NREG-1:0]          data_we,
  input  logic [DW-1:0]            new_data,
  output logic [NREG-1:0]          valid_q,
  output logic [NREG-1:0][TW-1:0]  tag_q,
  output logic [NREG-1:0][DW-1:0]  data_q
);

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
      end else begin
        unique case (vsel[i])
          VS_SET:   valid_q[i] <= 1'b1;
          VS_CLEAR: valid_q[i] <= 1'b0;
          default:  valid_q[i] <= valid_q[i];
        endcase
        if (tag_we[i])  tag_q[i]  <= new_tag;
        if (data_we[i]) data_q[i] <= new_data;
      end
    end
  end

endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [RW-1:0]            addr,
  input  logic [NREG-1:0]          valid_q,
  input  logic [NREG-1:0][TW-1:0]  tag_q,
  input  logic [NREG-1:0][DW-1:0]  data_q,
  input  logic                     cmt_valid,
  input  logic [RW-1:0]            cmt_reg,
  input  logic [TW-1:0]            cmt_tag,
  input  logic [DW-1:0]            cmt_data,
  output logic [DW-1:0]            data,
  output logic                     valid,
  output logic [TW-1:0]            tag
);

  logic bypass;

  assign bypass = cmt_valid && (cmt_reg == addr);
  assign data   = bypass ? cmt_data : data_q[addr];
  assign tag    = tag_q[addr];
  assign valid  = valid_q[addr] || (bypass && (tag_q[addr] == cmt_tag));

endmodule

// File: rtl/rename_regfile.sv
module rename_regfile
  import rrf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 3,
  parameter int NRD  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     ren_valid,
  output logic                     ren_ready,
  input  logic [RW-1:0]            ren_reg,
  input  logic [TW-1:0]            ren_tag,
  input  logic                     cmt_valid,
  input  logic [RW-1:0]            cmt_reg,
  input  logic [TW-1:0]            cmt_tag,
  input  logic [DW-1:0]            cmt_data,
  input  logic [NRD-1:0][RW-1:0]   rd_addr,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  output logic [NRD-1:0]           rd_valid,
  output logic [NRD-1:0][TW-1:0]   rd_tag
);

  logic                    ren_fire;
  vsel_e                   vsel    [NREG];
  logic [NREG-1:0]         tag_we;
  logic [NREG-1:0]         data_we;
  logic [NREG-1:0]         valid_q;
  logic [NREG-1:0][TW-1:0] tag_q;
  logic [NREG-1:0][DW-1:0] data_q;

  assign ren_ready = !flush;
  assign ren_fire  = ren_valid && ren_ready;

  rrf_update_ctl #(.NREG(NREG), .TW(TW)) u_ctl (
    .flush     (flush),
    .ren_fire  (ren_fire),
    .ren_reg   (ren_reg),
    .cmt_valid (cmt_valid),
    .cmt_reg   (cmt_reg),
    .cmt_tag   (cmt_tag),
    .cur_valid (valid_q),
    .cur_tag   (tag_q),
    .vsel      (vsel),
    .tag_we    (tag_we),
    .data_we   (data_we)
  );

  rrf_state #(.NREG(NREG), .DW(DW), .TW(TW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsel     (vsel),
    .tag_we   (tag_we),
    .new_tag  (ren_tag),
    .data_we  (data_we),
    .new_data (cmt_data),
    .valid_q  (valid_q),
    .tag_q    (tag_q),
    .data_q   (data_q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rrf_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_port (
      .addr      (rd_addr[p]),
      .valid_q   (valid_q),
      .tag_q     (tag_q),
      .data_q    (data_q),
      .cmt_valid (cmt_valid),
      .cmt_reg   (cmt_reg),
      .cmt_tag   (cmt_tag),
      .cmt_data  (cmt_data),
      .data      (rd_data[p]),
      .valid     (rd_valid[p]),
      .tag       (rd_tag[p])
    );
  end

endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 3,
  parameter int NRD  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     flush,
  input logic                     ren_valid,
  input logic                     ren_ready,
  input logic [RW-1:0]            ren_reg,
  input logic [TW-1:0]            ren_tag,
  input logic                     cmt_valid,
  input logic [RW-1:0]            cmt_reg,
  input logic [TW-1:0]            cmt_tag,
  input logic [DW-1:0]            cmt_data,
  input logic [NRD-1:0][RW-1:0]   rd_addr,
  input logic [NRD-1:0][DW-1:0]   rd_data,
  input logic [NREG-1:0]          valid_q,
  input logic [NREG-1:0][TW-1:0]  tag_q,
  input logic [NREG-1:0][DW-1:0]  data_q
);

  logic ren_acc, same_reg;
  assign ren_acc  = ren_valid && ren_ready;
  assign same_reg = ren_acc && (ren_reg == cmt_reg);

  AST_RENAME_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ren_acc |=> !valid_q[$past(ren_reg)] && tag_q[$past(ren_reg)] == $past(ren_tag)); // R3

  AST_FLUSH_NO_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> tag_q[$past(ren_reg)] == $past(tag_q[ren_reg])); // R4

  AST_FLUSH_ALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> &valid_q); // R9

  AST_RETIRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !valid_q[cmt_reg] && tag_q[cmt_reg] == cmt_tag && !same_reg)
      |=> valid_q[$past(cmt_reg)]); // R5

  AST_STALE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !flush && !valid_q[cmt_reg] && tag_q[cmt_reg] != cmt_tag && !same_reg)
      |=> !valid_q[$past(cmt_reg)] && tag_q[$past(cmt_reg)] == $past(tag_q[cmt_reg])); // R6

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && valid_q[cmt_reg] && !same_reg) |=> valid_q[$past(cmt_reg)]); // R7

  AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> data_q[$past(cmt_reg)] == $past(cmt_data)); // R5

  AST_RENAME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && same_reg) |=> !valid_q[$past(cmt_reg)]); // R8

  always_comb begin
    if (rst_n) begin
      for (int p = 0; p < NRD; p++) begin
        if (cmt_valid && rd_addr[p] == cmt_reg)
          AST_BYPASS_DATA: assert (rd_data[p] == cmt_data); // R10
      end
    end
  end

endmodule

bind rename_regfile rrf_checker #(.NREG(NREG), .DW(DW), .TW(TW), .NRD(NRD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .ren_valid (ren_valid),
  .ren_ready (ren_ready),
  .ren_reg   (ren_reg),
  .ren_tag   (ren_tag),
  .cmt_valid (cmt_valid),
  .cmt_reg   (cmt_reg),
  .cmt_tag   (cmt_tag),
  .cmt_data  (cmt_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .valid_q   (valid_q),
  .tag_q     (tag_q),
  .data_q    (data_q)
);

// File: tb/sim_rename_regfile.sv
module sim_rename_regfile;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush = 1'b0;
  logic             ren_valid = 1'b0;
  logic             ren_ready;
  logic [3:0]       ren_reg = '0;
  logic [2:0]       ren_tag = '0;
  logic             cmt_valid = 1'b0;
  logic [3:0]       cmt_reg = '0;
  logic [2:0]       cmt_tag = '0;
  logic [31:0]      cmt_data = '0;
  logic [1:0][3:0]  rd_addr = '0;
  logic [1:0][31:0] rd_data;
  logic [1:0]       rd_valid;
  logic [1:0][2:0]  rd_tag;

  always #4 clk = ~clk;  // 125 MHz

  rename_regfile u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_reg(ren_reg), .ren_tag(ren_tag),
    .cmt_valid(cmt_valid), .cmt_reg(cmt_reg), .cmt_tag(cmt_tag), .cmt_data(cmt_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .rd_tag(rd_tag)
  );

  typedef struct {
    int         port;
    logic [3:0] addr;
    logic [31:0] data;
    logic       valid;
    logic [2:0] tag;
    string      req;
  } item_t;

  item_t q[$];
  bit    busy = 0;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;

  // expected state, from the requirements
  logic [31:0] m_data [16];
  logic        m_valid[16];
  logic [2:0]  m_tag  [16];

  // monitor: pops expectations and compares against the read ports
  initial forever begin
    wait (q.size() > 0);
    busy = 1;
    begin
      item_t it;
      it = q.pop_front();
      rd_addr[it.port] = it.addr;
      #1;
      n_run++;
      if (rd_data[it.port] !== it.data || rd_valid[it.port] !== it.valid ||
          rd_tag[it.port] !== it.tag) begin
        n_fail++;
        $display("FAIL %s port%0d reg%0d: got data=%h ready=%b tag=%0d, expected data=%h ready=%b tag=%0d",
                 it.req, it.port, it.addr, rd_data[it.port], rd_valid[it.port],
                 rd_tag[it.port], it.data, it.valid, it.tag);
      end
    end
    busy = 0;
  end

  task automatic expect_reg(input int port, input int r, input string req);
    item_t it;
    it.port = port; it.addr = 4'(r); it.data = m_data[r];
    it.valid = m_valid[r]; it.tag = m_tag[r]; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0 && !busy);
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < 16; r++) expect_reg(r % 2, r, req);
    drain();
  endtask

  task automatic apply_model(input bit f, input bit rv, input int rr, input logic [2:0] rt,
                             input bit cv, input int cr, input logic [2:0] ct,
                             input logic [31:0] cd);
    if (cv) begin
      m_data[cr] = cd;
      if (!m_valid[cr] && m_tag[cr] == ct) m_valid[cr] = 1'b1;
    end
    if (f) begin
      for (int r = 0; r < 16; r++) m_valid[r] = 1'b1;
    end else if (rv) begin
      m_valid[rr] = 1'b0;
      m_tag[rr] = rt;
    end
  endtask

  task automatic drive(input bit f, input bit rv, input int rr, input logic [2:0] rt,
                       input bit cv, input int cr, input logic [2:0] ct,
                       input logic [31:0] cd);
    flush = f; ren_valid = rv; ren_reg = 4'(rr); ren_tag = rt;
    cmt_valid = cv; cmt_reg = 4'(cr); cmt_tag = ct; cmt_data = cd;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic op(input bit f, input bit rv, input int rr, input logic [2:0] rt,
                    input bit cv, input int cr, input logic [2:0] ct,
                    input logic [31:0] cd);
    @(negedge clk);
    drive(f, rv, rr, rt, cv, cr, ct, cd);
    apply_model(f, rv, rr, rt, cv, cr, ct, cd);
    @(negedge clk);
    idle();
  endtask

  task automatic rename(input int r, input logic [2:0] t);
    op(0, 1, r, t, 0, 0, 0, 0);
  endtask

  task automatic commit(input int r, input logic [2:0] t, input logic [31:0] d);
    op(0, 0, 0, 0, 1, r, t, d);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 16; r++) begin
      m_data[r] = '0; m_valid[r] = 1'b1; m_tag[r] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check_all("R1 reset state");

    // R7: commit to a ready register
    commit(5, 3'd2, 32'hA5A5_0005);
    expect_reg(0, 5, "R7 ready stays ready");
    expect_reg(1, 5, "R2 second port");
    drain();

    // R3 and R11: rename makes pending, value kept
    rename(3, 3'd2);
    rename(0, 3'd5);
    expect_reg(0, 3, "R3 rename pends");
    expect_reg(1, 0, "R11 reg0 renamed");
    drain();

    // R5: matching commit
    commit(3, 3'd2, 32'h1111_3333);
    commit(0, 3'd5, 32'h0000_00F0);
    expect_reg(1, 3, "R5 matching commit");
    expect_reg(0, 0, "R11 reg0 retired");
    drain();

    // R6: older writer retires after a younger rename
    rename(7, 3'd1);
    rename(7, 3'd4);
    commit(7, 3'd1, 32'hDEAD_0001);
    expect_reg(0, 7, "R6 stale commit stays pending");
    drain();
    commit(7, 3'd4, 32'hBEEF_0004);
    expect_reg(1, 7, "R5 youngest commit lands");
    drain();

    // R8: rename and commit on the same register, same cycle
    rename(9, 3'd3);
    op(0, 1, 9, 3'd6, 1, 9, 3'd3, 32'h9999_0003);
    expect_reg(0, 9, "R8 rename wins over commit");
    drain();

    // R10: same-cycle bypass, matching and stale
    rename(10, 3'd1);
    rename(10, 3'd2);
    @(negedge clk);
    drive(0, 0, 0, 0, 1, 9, 3'd6, 32'h7777_0006);
    begin
      item_t it;
      it.port = 0; it.addr = 4'd9; it.data = 32'h7777_0006; it.valid = 1'b1;
      it.tag = 3'd6; it.req = "R10 bypass matching";
      q.push_back(it);
      expect_reg(1, 10, "R2 other port unaffected");
    end
    drain();
    apply_model(0, 0, 0, 0, 1, 9, 3'd6, 32'h7777_0006);
    @(negedge clk);
    drive(0, 0, 0, 0, 1, 10, 3'd1, 32'h0A0A_0001);
    begin
      item_t it;
      it.port = 1; it.addr = 4'd10; it.data = 32'h0A0A_0001; it.valid = 1'b0;
      it.tag = 3'd2; it.req = "R10 bypass stale";
      q.push_back(it);
    end
    drain();
    apply_model(0, 0, 0, 0, 1, 10, 3'd1, 32'h0A0A_0001);
    @(negedge clk);
    idle();

    // R4 and R9: flush with a rename offered
    rename(12, 3'd7);
    @(negedge clk);
    drive(1, 1, 4, 3'd3, 0, 0, 0, 0);
    #1;
    n_run++;
    if (ren_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R4 ren_ready during flush: got %b expected 0", ren_ready);
    end
    apply_model(1, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    idle();
    check_all("R9 flush clears pending, R4 rename ignored");

    // after flush, renaming resumes
    rename(12, 3'd1);
    expect_reg(0, 12, "R3 rename after flush");
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule